// File: doc/BRIEF.md
# Escaped Byte Stream Packet Deframer

This block sits behind a serial receiver and turns its byte stream into packets. Every accepted input byte is classified. Idle fill is dropped. Two stacked escape schemes are undone: a physical-layer escape that protects the idle code, and a framing-layer escape that protects the framing markers. Start, end and channel markers are located, and the remaining data bytes leave on a valid/ready output. Each output byte carries a start flag, an end flag and the channel number currently in force.

The end marker comes before the last data byte of a packet, not after it. The block therefore keeps a pending end flag and attaches it to the next data byte. A malformed marker sequence raises a one-cycle error pulse. The parser then drops input until the next start marker. Upstream logic gets one input byte per accepted cycle, and input is taken only while no output byte is waiting.

Top module: `escstream_deframer`

## Requirements
- R1: Every byte that arrives before the first start code 0x7A is discarded. After a byte that carries the end flag, input is discarded until the next start code.
- R2: The idle code 0x4A, when not escaped, is discarded wherever it appears in a packet and has no effect on the output.
- R3: After the framing escape 0x7D or the physical escape 0x4D, the next byte is XORed with 0x20 and delivered as a data byte.
- R4: After the channel code 0x7C, the next non-idle byte is taken as the channel number. That byte is not delivered. `out_chan` carries it on every later data byte of the packet.
- R5: Each start code resets the channel to 0, so a packet without a channel code is delivered with `out_chan` = 0.
- R6: The first data byte after a start code has `out_sop` = 1. Every other data byte has `out_sop` = 0.
- R7: The end code 0x7B makes the next data byte carry `out_eop` = 1, and that byte ends the packet. A packet may be a single byte with both flags set.
- R8: A start code inside a packet restarts assembly. It clears any pending escape, end or channel state, and the next data byte is a new first byte.
- R9: Each of these is an error: a second escape while an escape is pending; an end or channel code right after an escape; an end or channel code while an end is pending. An error drives `err` high for exactly one cycle, one cycle after the offending byte is accepted, and input is then discarded until the next start code.
- R10: `in_ready` is high only while no output byte is waiting. A waiting output keeps `out_valid` high and its data and flags stable until `out_ready` is seen high.
- R11: After reset, `out_valid` and `err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Raw received byte |
| in_ready | output | 1 | Block takes the input byte this cycle |
| out_valid | output | 1 | Output byte waiting |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Decoded data byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_chan | output | 8 | Channel number of the packet |
| err | output | 1 | One-cycle protocol error pulse |

## Verification
A single stream strings many short frames together, so each frame starts from the state the previous one left behind. Leading junk, idle fill and trailing bytes after an end separate dropping from delivery. Escaped framing and idle codes, plus a channel-bearing frame followed by one without a channel, show whether the XOR is applied and whether the channel resets. Every error case and a mid-packet restart under a pending escape show whether the marker state is cleared. Directed tests stall the output to show that it holds and that input is refused, and they count the width of the error pulse.

// File: rtl/pkt_defs_pkg.sv
package pkt_defs_pkg;

  localparam int BYTE_W      = 8;
  localparam int NUM_SPECIAL = 6;
  localparam logic [BYTE_W-1:0] ESC_XOR = 8'h20;

  typedef enum logic [2:0] {
    CLS_SOP    = 3'd0,
    CLS_EOP    = 3'd1,
    CLS_CHAN   = 3'd2,
    CLS_PESC   = 3'd3,
    CLS_IDLE   = 3'd4,
    CLS_PHYESC = 3'd5,
    CLS_DATA   = 3'd6
  } byte_cls_e;

  // marker value for each special class, indexed by class number
  function automatic logic [BYTE_W-1:0] code_of(input int idx);
    case (idx)
      0:       return 8'h7A;
      1:       return 8'h7B;
      2:       return 8'h7C;
      3:       return 8'h7D;
      4:       return 8'h4A;
      default: return 8'h4D;
    endcase
  endfunction

endpackage

// File: rtl/dfr_classify.sv
module dfr_classify
  import pkt_defs_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output byte_cls_e         cls_o
);

  logic [NUM_SPECIAL-1:0] hit;

  for (genvar gi = 0; gi < NUM_SPECIAL; gi++) begin : g_match
    assign hit[gi] = (byte_i == code_of(gi));
  end

  always_comb begin
    cls_o = CLS_DATA;
    for (int k = NUM_SPECIAL - 1; k >= 0; k--) begin
      if (hit[k]) cls_o = byte_cls_e'(k[2:0]);
    end
  end

endmodule

// File: rtl/dfr_parser.sv
module dfr_parser
  import pkt_defs_pkg::*;
#(
  parameter int CHAN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  byte_cls_e         cls_i,
  output logic              emit_o,
  output logic [BYTE_W-1:0] emit_data_o,
  output logic              emit_sop_o,
  output logic              emit_eop_o,
  output logic [CHAN_W-1:0] emit_chan_o,
  output logic              err_o
);

  logic              hunt_q, hunt_d;
  logic              esc_q, esc_d;
  logic              eop_q, eop_d;
  logic              chp_q, chp_d;
  logic              first_q, first_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              err_q, err_det;
  logic              emit;
  logic              restart;

  always_comb begin
    hunt_d  = hunt_q;
    esc_d   = esc_q;
    eop_d   = eop_q;
    chp_d   = chp_q;
    first_d = first_q;
    chan_d  = chan_q;
    emit    = 1'b0;
    err_det = 1'b0;
    restart = 1'b0;
    if (acc_i) begin
      if (hunt_q) begin
        restart = (cls_i == CLS_SOP);
      end else if (cls_i == CLS_IDLE) begin
        // fill byte: no state change
      end else if (chp_q) begin
        chan_d = CHAN_W'(byte_i);
        chp_d  = 1'b0;
      end else begin
        case (cls_i)
          CLS_SOP: restart = 1'b1;
          CLS_EOP: begin
            if (esc_q || eop_q) err_det = 1'b1;
            else                eop_d   = 1'b1;
          end
          CLS_CHAN: begin
            if (esc_q || eop_q) err_det = 1'b1;
            else                chp_d   = 1'b1;
          end
          CLS_PESC, CLS_PHYESC: begin
            if (esc_q) err_det = 1'b1;
            else       esc_d   = 1'b1;
          end
          default: begin
            emit    = 1'b1;
            esc_d   = 1'b0;
            first_d = 1'b0;
            if (eop_q) begin
              eop_d  = 1'b0;
              hunt_d = 1'b1;
            end
          end
        endcase
      end
      if (restart) begin
        hunt_d  = 1'b0;
        esc_d   = 1'b0;
        eop_d   = 1'b0;
        chp_d   = 1'b0;
        first_d = 1'b1;
        chan_d  = '0;
      end
      if (err_det) begin
        hunt_d = 1'b1;
        esc_d  = 1'b0;
        eop_d  = 1'b0;
        chp_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hunt_q  <= 1'b1;
      esc_q   <= 1'b0;
      eop_q   <= 1'b0;
      chp_q   <= 1'b0;
      first_q <= 1'b0;
      chan_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      hunt_q  <= hunt_d;
      esc_q   <= esc_d;
      eop_q   <= eop_d;
      chp_q   <= chp_d;
      first_q <= first_d;
      chan_q  <= chan_d;
      err_q   <= err_det;
    end
  end

  assign emit_o      = emit;
  assign emit_data_o = esc_q ? (byte_i ^ ESC_XOR) : byte_i;
  assign emit_sop_o  = first_q;
  assign emit_eop_o  = eop_q;
  assign emit_chan_o = chan_q;
  assign err_o       = err_q;

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !err_q); // R9
  AST_HUNT_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
    err_q |-> hunt_q); // R9
  AST_ESC_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    emit |=> !esc_q); // R3
  AST_END_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (emit && eop_q) |=> (hunt_q && !first_q)); // R7

endmodule

// File: rtl/dfr_outreg.sv
module dfr_outreg
  import pkt_defs_pkg::*;
#(
  parameter int CHAN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic [CHAN_W-1:0] chan_o
);

  localparam int PAY_W = BYTE_W + CHAN_W + 2;

  logic             valid_q;
  logic [PAY_W-1:0] pay_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      pay_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      pay_q   <= {sop_i, eop_i, chan_i, data_i};
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = pay_q[BYTE_W-1:0];
  assign chan_o  = pay_q[BYTE_W +: CHAN_W];
  assign eop_o   = pay_q[PAY_W-2];
  assign sop_o   = pay_q[PAY_W-1];

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !valid_q); // R10
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready_i) |=> (valid_q && $stable(pay_q))); // R10

endmodule

// File: rtl/escstream_deframer.sv
module escstream_deframer
  import pkt_defs_pkg::*;
#(
  parameter int CHAN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [CHAN_W-1:0] out_chan,
  output logic              err
);

  byte_cls_e         cls;
  logic              acc;
  logic              emit;
  logic [BYTE_W-1:0] emit_data;
  logic              emit_sop, emit_eop;
  logic [CHAN_W-1:0] emit_chan;

  assign in_ready = !out_valid;
  assign acc      = in_valid && in_ready;

  dfr_classify u_cls (
    .byte_i (in_byte),
    .cls_o  (cls)
  );

  dfr_parser #(.CHAN_W(CHAN_W)) u_parse (
    .clk         (clk),
    .rst         (rst),
    .acc_i       (acc),
    .byte_i      (in_byte),
    .cls_i       (cls),
    .emit_o      (emit),
    .emit_data_o (emit_data),
    .emit_sop_o  (emit_sop),
    .emit_eop_o  (emit_eop),
    .emit_chan_o (emit_chan),
    .err_o       (err)
  );

  dfr_outreg #(.CHAN_W(CHAN_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load_i  (emit),
    .data_i  (emit_data),
    .sop_i   (emit_sop),
    .eop_i   (emit_eop),
    .chan_i  (emit_chan),
    .valid_o (out_valid),
    .ready_i (out_ready),
    .data_o  (out_data),
    .sop_o   (out_sop),
    .eop_o   (out_eop),
    .chan_o  (out_chan)
  );

  AST_IDLE_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !err)); // R11

endmodule

// File: tb/escstream_deframer_bench.sv
module escstream_deframer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_sop, out_eop;
  logic [7:0] out_chan;
  logic       err;

  always #2.5 clk = ~clk;

  escstream_deframer u_escstream_deframer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .out_chan(out_chan), .err(err)
  );

  localparam int NSTIM = 50;
  localparam int NEXP  = 17;

  localparam logic [7:0] STIM [0:NSTIM-1] = '{
    8'h11, 8'h4A, 8'h7A, 8'h01, 8'h4A, 8'h02, 8'h7B, 8'h03,
    8'h7A, 8'h7C, 8'h05, 8'h7D, 8'h5A, 8'h4D, 8'h6A, 8'h7B, 8'h4D, 8'h6D,
    8'h7A, 8'h21, 8'h7A, 8'h22, 8'h7B, 8'h23, 8'h24,
    8'h7A, 8'h31, 8'h7D, 8'h7D, 8'h32,
    8'h7A, 8'h7D, 8'h7B, 8'h40,
    8'h7A, 8'h7B, 8'h7C, 8'h50,
    8'h7A, 8'h7B, 8'h7B,
    8'h7A, 8'h7B, 8'h41,
    8'h7A, 8'h7D, 8'h7A, 8'h42, 8'h7B, 8'h43
  };

  // {kind(01 data, 10 error), sop, eop, chan, data}
  localparam logic [19:0] EXP [0:NEXP-1] = '{
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h01},
    {2'b01, 1'b0, 1'b0, 8'h00, 8'h02},
    {2'b01, 1'b0, 1'b1, 8'h00, 8'h03},
    {2'b01, 1'b1, 1'b0, 8'h05, 8'h7A},
    {2'b01, 1'b0, 1'b0, 8'h05, 8'h4A},
    {2'b01, 1'b0, 1'b1, 8'h05, 8'h4D},
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h21},
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h22},
    {2'b01, 1'b0, 1'b1, 8'h00, 8'h23},
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h31},
    {2'b10, 18'h0},
    {2'b10, 18'h0},
    {2'b10, 18'h0},
    {2'b10, 18'h0},
    {2'b01, 1'b1, 1'b1, 8'h00, 8'h41},
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h42},
    {2'b01, 1'b0, 1'b1, 8'h00, 8'h43}
  };

  function automatic string tag_of(input int idx);
    case (idx)
      0:       return "R1";
      1:       return "R2";
      2, 8, 16: return "R7";
      3, 5:    return "R3";
      4:       return "R4";
      6:       return "R5";
      7, 15:   return "R8";
      9:       return "R6";
      14:      return "R7";
      default: return "R9";
    endcase
  endfunction

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int err_cnt = 0;
  int out_cnt = 0;
  logic        log_en = 1'b0;
  logic [19:0] got [0:63];
  int got_n = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (err) err_cnt++;
      if (out_valid && out_ready) out_cnt++;
      if (log_en && got_n < 64) begin
        if (out_valid && out_ready) begin
          got[got_n] = {2'b01, out_sop, out_eop, out_chan, out_data};
          got_n++;
        end
        if (err) begin
          got[got_n] = {2'b10, 18'h0};
          got_n++;
        end
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int e0, o0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check(out_valid == 1'b0, "R11", {31'd0, out_valid}, 32'd0);
    check(err == 1'b0, "R11", {31'd0, err}, 32'd0);
    check(in_ready == 1'b1, "R11", {31'd0, in_ready}, 32'd1);

    // table-driven stream
    log_en = 1'b1;
    for (int i = 0; i < NSTIM; i++) send(STIM[i]);
    idle(4);
    log_en = 1'b0;
    check(got_n == NEXP, "R1", got_n, NEXP);
    for (int i = 0; i < NEXP; i++) begin
      if (i < got_n) check(got[i] == EXP[i], tag_of(i), {12'd0, got[i]}, {12'd0, EXP[i]});
    end

    // R10: stalled output holds, input refused
    out_ready = 1'b0;
    send(8'h7A);
    send(8'h55);
    idle(3);
    check(out_valid && out_data == 8'h55 && out_sop, "R10",
          {23'd0, out_valid, out_data}, {23'd1, 8'h55});
    check(in_ready == 1'b0, "R10", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b1;
    in_byte  = 8'h66;
    idle(2);
    check(out_data == 8'h55 && out_valid, "R10", {24'd0, out_data}, {24'd0, 8'h55});
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == 8'h66 && !out_sop, "R10",
          {22'd0, out_valid, out_sop, out_data}, {22'd2, 8'h66});
    idle(2);

    // R9: error pulse is one cycle wide and input is dropped afterwards
    e0 = err_cnt;
    send(8'h7D);
    send(8'h7D);
    idle(4);
    check(err_cnt - e0 == 1, "R9", err_cnt - e0, 1);
    o0 = out_cnt;
    send(8'h88);
    send(8'h7B);
    send(8'h89);
    idle(3);
    check(out_cnt == o0, "R9", out_cnt - o0, 0);

    // R2: idle between start and data has no effect; recovery after error
    send(8'h7A);
    send(8'h4A);
    send(8'h99);
    idle(1);
    check(out_cnt == o0 + 1, "R2", out_cnt - o0, 1);
    idle(3);
    finish_run();
  end

  // capture for the recovery byte
  always @(negedge clk) begin
    if (!rst && !log_en && out_valid && out_ready && out_data == 8'h99) begin
      check(out_sop && !out_eop && out_chan == 8'h00, "R6",
            {30'd0, out_sop, out_eop}, 32'd2);
    end
  end

endmodule